// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between an 8-bit host bus and three counting channels of an interval timer. The host reaches it through a 2-bit address: addresses 0, 1 and 2 are the data ports of the matching channel, and address 3 takes control words. The block turns control words into a per-channel counting mode, byte access mode and decimal flag. It turns data-port writes into 16-bit count-load strobes. It serves data-port reads from a latched status byte, a frozen copy of the count, or the count that is running now.

The counters are outside this block. Each channel gives back its running count and its OUT level, and the block samples them when the host asks for a latch. A 16-bit count moves over the 8-bit bus as two bytes. Each channel therefore has a write toggle and a read toggle, and they are independent. A programming word clears both toggles. A read-back command can freeze the count and/or the status of any set of channels in one write.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel reports counting mode 0, access mode 3 (low byte then high byte), decimal flag 0 and no pending latch. Read data and all load strobes are 0.
- R2: A write to address 3 whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are nonzero programs that channel. Bits 5:4 set the access mode, bits 3:1 the counting mode and bit 0 the decimal flag, and the channel's read and write byte toggles are cleared.
- R3: In access mode 1 a data write loads {8'h00, byte}, and in access mode 2 it loads {byte, 8'h00]. The channel's load strobe is high for the one cycle after the write edge, and the loaded value is held on the load-value output.
- R4: In access mode 3 the first data write only stores the byte and gives no strobe. The second write loads {second byte, first byte}.
- R5: A control word with access bits 00 freezes that channel's running count as it stands at the write edge. Reads then return it as the access mode dictates, and in mode 3 they return the low byte and then the high byte. The read that completes the transfer releases the latch, and later reads return the running count.
- R6: A count latch request is ignored while an earlier latched count on that channel is unread. A status latch request is ignored while an earlier status byte is unread.
- R7: A write to address 3 with bits 7:6 = 3 is a read-back command. Bit (channel+1) selects a channel. Bit 5 at 0 asks for a count latch and bit 4 at 0 asks for a status latch on every selected channel.
- R8: The status byte is {OUT, 0, access mode[1:0], counting mode[2:0], decimal flag}, with OUT sampled at the command's write edge.
- R9: A data read returns a pending status byte first, then a pending latched count, then the running count.
- R10: Running-count reads return the low byte in mode 1 and the high byte in mode 2. In mode 3 they alternate low, high, low, starting from low after programming.
- R11: A read of address 3 returns 0 and leaves every channel's byte toggles and latches unchanged. Control writes never raise a load strobe.
- R12: Read data is registered: it shows the addressed byte in the cycle after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Port select: 0-2 channel data, 3 control |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| ld_stb | output | NUM_CH | Per-channel count-load strobe |
| ld_val | output | NUM_CH*16 | Per-channel loaded count, channel c at [16c +: 16] |
| ch_mode | output | NUM_CH*3 | Per-channel counting mode |
| ch_acc | output | NUM_CH*2 | Per-channel byte access mode |
| ch_bcd | output | NUM_CH | Per-channel decimal flag |
| live_cnt | input | NUM_CH*16 | Running count from each counter |
| ch_out | input | NUM_CH | OUT level from each counter |

## Verification
The hardest states to reach are the stacked ones. A channel can hold an unread status byte and an unread word-wide latched count at once, and further latch requests must leave both alone. The stimulus issues a read-back that latches both on two channels. It then changes the running counts and OUT levels before any read, so a value taken at the wrong time differs from the expected one. A second latch request arrives while the first is still pending. The reads then walk the priority order byte by byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        acc_e              acc;
        logic              bcd;
        logic              wr_hi;
        logic [BYTE_W-1:0] wbyte;
        logic              rd_hi;
        acc_e              lat_st;
        logic [CNT_W-1:0]  lat_val;
        logic              stat_vld;
        logic [BYTE_W-1:0] stat;
        logic              ld_stb;
        logic [CNT_W-1:0]  ld_val;
    } chan_st_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [1:0]        addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [NUM_CH-1:0] prog_o,
    output logic [NUM_CH-1:0] cnt_lat_o,
    output logic [NUM_CH-1:0] stat_lat_o,
    output logic [NUM_CH-1:0] dwr_o,
    output logic [NUM_CH-1:0] drd_o
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL    = 2'd3;

    logic ctrl_wr;
    logic is_rb;
    logic [1:0] sel;
    logic [1:0] acc_f;

    assign ctrl_wr = wr_i && (addr_i == CTRL_ADDR);
    assign sel     = wdata_i[7:6];
    assign acc_f   = wdata_i[5:4];
    assign is_rb   = (sel == RB_SEL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [1:0] CH_IDX = 2'(c);
        logic rb_pick;
        assign rb_pick       = is_rb && wdata_i[c+1];
        assign prog_o[c]     = ctrl_wr && !is_rb && (sel == CH_IDX) && (acc_f != 2'd0);
        assign cnt_lat_o[c]  = ctrl_wr && ((!is_rb && (sel == CH_IDX) && (acc_f == 2'd0))
                                           || (rb_pick && !wdata_i[5]));
        assign stat_lat_o[c] = ctrl_wr && rb_pick && !wdata_i[4];
        assign dwr_o[c]      = wr_i && (addr_i == CH_IDX);
        assign drd_o[c]      = rd_i && (addr_i == CH_IDX);
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  logic              cnt_lat_i,
    input  logic              stat_lat_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  live_i,
    input  logic              out_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [1:0]        acc_o,
    output logic              bcd_o,
    output logic              ld_stb_o,
    output logic [CNT_W-1:0]  ld_val_o,
    output logic [BYTE_W-1:0] rbyte_o
);
    chan_st_t q, d;

    localparam chan_st_t RST_ST = '{
        mode: '0, acc: ACC_WORD, bcd: 1'b0, wr_hi: 1'b0, wbyte: '0,
        rd_hi: 1'b0, lat_st: ACC_LATCH, lat_val: '0, stat_vld: 1'b0,
        stat: '0, ld_stb: 1'b0, ld_val: '0
    };

    always_comb begin
        d = q;
        d.ld_stb = 1'b0;

        if (prog_i) begin
            d.acc   = acc_e'(wdata_i[5:4]);
            d.mode  = wdata_i[3:1];
            d.bcd   = wdata_i[0];
            d.wr_hi = 1'b0;
            d.rd_hi = 1'b0;
        end else if (wr_i) begin
            unique case (q.acc)
                ACC_LO: begin
                    d.ld_stb = 1'b1;
                    d.ld_val = {{BYTE_W{1'b0}}, wdata_i};
                end
                ACC_HI: begin
                    d.ld_stb = 1'b1;
                    d.ld_val = {wdata_i, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    if (!q.wr_hi) begin
                        d.wbyte = wdata_i;
                        d.wr_hi = 1'b1;
                    end else begin
                        d.ld_stb = 1'b1;
                        d.ld_val = {wdata_i, q.wbyte};
                        d.wr_hi  = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (cnt_lat_i && (q.lat_st == ACC_LATCH)) begin
            d.lat_st  = q.acc;
            d.lat_val = live_i;
        end

        if (stat_lat_i && !q.stat_vld) begin
            d.stat     = {out_i, 1'b0, q.acc, q.mode, q.bcd};
            d.stat_vld = 1'b1;
        end

        if (rd_i) begin
            if (q.stat_vld) begin
                d.stat_vld = 1'b0;
            end else if (q.lat_st != ACC_LATCH) begin
                d.lat_st = (q.lat_st == ACC_WORD) ? ACC_HI : ACC_LATCH;
            end else if (q.acc == ACC_WORD) begin
                d.rd_hi = !q.rd_hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_ST;
        else        q <= d;
    end

    always_comb begin
        if (q.stat_vld) begin
            rbyte_o = q.stat;
        end else if (q.lat_st != ACC_LATCH) begin
            rbyte_o = (q.lat_st == ACC_HI) ? q.lat_val[CNT_W-1:BYTE_W]
                                           : q.lat_val[BYTE_W-1:0];
        end else begin
            unique case (q.acc)
                ACC_HI:   rbyte_o = live_i[CNT_W-1:BYTE_W];
                ACC_WORD: rbyte_o = q.rd_hi ? live_i[CNT_W-1:BYTE_W] : live_i[BYTE_W-1:0];
                default:  rbyte_o = live_i[BYTE_W-1:0];
            endcase
        end
    end

    assign mode_o   = q.mode;
    assign acc_o    = q.acc;
    assign bcd_o    = q.bcd;
    assign ld_stb_o = q.ld_stb;
    assign ld_val_o = q.ld_val;

    assert_load_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb_o |-> $past(wr_i));

    assert_first_byte_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wr_hi) |-> !ld_stb_o);

    assert_prog_clears_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> (!q.wr_hi && !q.rd_hi));

    assert_count_latch_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.lat_st != ACC_LATCH) && !rd_i) |=> $stable(q.lat_val));

    assert_status_latch_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stat_vld && !rd_i) |=> (q.stat_vld && $stable(q.stat)));

    assert_status_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stat_vld && rd_i) |=> $stable(q.lat_st));
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                addr,
    input  logic [BYTE_W-1:0]         wdata,
    input  logic                      wr_en,
    input  logic                      rd_en,
    output logic [BYTE_W-1:0]         rdata,
    output logic [NUM_CH-1:0]         ld_stb,
    output logic [NUM_CH*CNT_W-1:0]   ld_val,
    output logic [NUM_CH*MODE_W-1:0]  ch_mode,
    output logic [NUM_CH*2-1:0]       ch_acc,
    output logic [NUM_CH-1:0]         ch_bcd,
    input  logic [NUM_CH*CNT_W-1:0]   live_cnt,
    input  logic [NUM_CH-1:0]         ch_out
);
    logic [NUM_CH-1:0] prog, cnt_lat, stat_lat, dwr, drd;
    logic [BYTE_W-1:0] rbyte [NUM_CH];
    logic [BYTE_W-1:0] rdata_d, rdata_q;
    logic [BYTE_W-1:0] rsel;

    tmr_cmd_decode #(.NUM_CH(NUM_CH)) i_dec (
        .addr_i     (addr),
        .wdata_i    (wdata),
        .wr_i       (wr_en),
        .rd_i       (rd_en),
        .prog_o     (prog),
        .cnt_lat_o  (cnt_lat),
        .stat_lat_o (stat_lat),
        .dwr_o      (dwr),
        .drd_o      (drd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tmr_chan i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .prog_i     (prog[c]),
            .cnt_lat_i  (cnt_lat[c]),
            .stat_lat_i (stat_lat[c]),
            .wr_i       (dwr[c]),
            .rd_i       (drd[c]),
            .wdata_i    (wdata),
            .live_i     (live_cnt[c*CNT_W +: CNT_W]),
            .out_i      (ch_out[c]),
            .mode_o     (ch_mode[c*MODE_W +: MODE_W]),
            .acc_o      (ch_acc[c*2 +: 2]),
            .bcd_o      (ch_bcd[c]),
            .ld_stb_o   (ld_stb[c]),
            .ld_val_o   (ld_val[c*CNT_W +: CNT_W]),
            .rbyte_o    (rbyte[c])
        );
    end

    always_comb begin
        rsel = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == 2'(c)) rsel = rbyte[c];
        end
        rdata_d = rd_en ? rsel : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    assert_ctrl_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 2'd3)) |=> (rdata == '0));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    assert_ctrl_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 2'd3)) |=> (ld_stb == '0));
endmodule

// File: tb/test_tmr_host_if.sv
module test_tmr_host_if;
    localparam int NC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [NC-1:0]    ld_stb;
    logic [NC*16-1:0] ld_val;
    logic [NC*3-1:0]  ch_mode;
    logic [NC*2-1:0]  ch_acc;
    logic [NC-1:0]    ch_bcd;
    logic [NC*16-1:0] live_cnt = '0;
    logic [NC-1:0]    ch_out = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tmr_host_if #(.NUM_CH(NC)) i_tmr_host_if (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .ld_stb(ld_stb), .ld_val(ld_val),
        .ch_mode(ch_mode), .ch_acc(ch_acc), .ch_bcd(ch_bcd),
        .live_cnt(live_cnt), .ch_out(ch_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic set_live(input int c, input logic [15:0] v);
        live_cnt[c*16 +: 16] = v;
    endtask

    task automatic t_reset;
        for (int c = 0; c < NC; c++) begin
            check("R1 mode", 16'(ch_mode[c*3 +: 3]), 16'd0);
            check("R1 acc", 16'(ch_acc[c*2 +: 2]), 16'd3);
            check("R1 bcd", 16'(ch_bcd[c]), 16'd0);
        end
        check("R1 rdata", 16'(rdata), 16'd0);
        check("R1 ld_stb", 16'(ld_stb), 16'd0);
    endtask

    task automatic t_program;
        bus_wr(2'd3, 8'h57);
        check("R2 ch1 acc", 16'(ch_acc[3:2]), 16'd1);
        check("R2 ch1 mode", 16'(ch_mode[5:3]), 16'd3);
        check("R2 ch1 bcd", 16'(ch_bcd[1]), 16'd1);
        check("R2 ch0 untouched", 16'({ch_acc[1:0], ch_mode[2:0], ch_bcd[0]}), 16'b11_000_0);
        check("R11 ctrl no strobe", 16'(ld_stb), 16'd0);
    endtask

    task automatic t_writes;
        bus_wr(2'd3, 8'h50);
        bus_wr(2'd1, 8'h5A);
        check("R3 lo strobe", 16'(ld_stb), 16'b010);
        check("R3 lo value", ld_val[31:16], 16'h005A);
        bus_wr(2'd3, 8'hA0);
        bus_wr(2'd2, 8'h3C);
        check("R3 hi strobe", 16'(ld_stb), 16'b100);
        check("R3 hi value", ld_val[47:32], 16'h3C00);
        bus_wr(2'd3, 8'h30);
        bus_wr(2'd0, 8'h34);
        check("R4 first byte no strobe", 16'(ld_stb), 16'd0);
        bus_wr(2'd0, 8'h12);
        check("R4 word strobe", 16'(ld_stb), 16'b001);
        check("R4 word value", ld_val[15:0], 16'h1234);
        @(negedge clk);
        check("R3 strobe one cycle", 16'(ld_stb), 16'd0);
    endtask

    task automatic t_prog_resets_toggle;
        bus_wr(2'd3, 8'h30);
        bus_wr(2'd0, 8'h77);
        bus_wr(2'd3, 8'h30);
        bus_wr(2'd0, 8'h11);
        check("R2 toggle cleared, no strobe", 16'(ld_stb), 16'd0);
        bus_wr(2'd0, 8'h22);
        check("R2 word after reprogram", ld_val[15:0], 16'h2211);
    endtask

    task automatic t_live_reads;
        logic [7:0] b;
        bus_wr(2'd3, 8'h30);
        set_live(0, 16'hABCD);
        bus_rd(2'd0, b); check("R10 word low", 16'(b), 16'h00CD);
        bus_rd(2'd0, b); check("R10 word high", 16'(b), 16'h00AB);
        bus_rd(2'd0, b); check("R10 word low again", 16'(b), 16'h00CD);
        bus_wr(2'd3, 8'h50);
        set_live(1, 16'h1357);
        bus_rd(2'd1, b); check("R10 lo only", 16'(b), 16'h0057);
        bus_rd(2'd1, b); check("R10 lo only repeat", 16'(b), 16'h0057);
        bus_wr(2'd3, 8'hA0);
        set_live(2, 16'h2468);
        bus_rd(2'd2, b); check("R10 hi only", 16'(b), 16'h0024);
        repeat (3) @(negedge clk);
        check("R12 rdata held", 16'(rdata), 16'h0024);
    endtask

    task automatic t_count_latch;
        logic [7:0] b;
        bus_wr(2'd3, 8'h30);
        set_live(0, 16'h1111);
        bus_wr(2'd3, 8'h00);
        set_live(0, 16'h2222);
        bus_rd(2'd0, b); check("R5 latched low", 16'(b), 16'h0011);
        bus_rd(2'd0, b); check("R5 latched high", 16'(b), 16'h0011);
        bus_rd(2'd0, b); check("R5 live after release", 16'(b), 16'h0022);
        bus_rd(2'd0, b);
        set_live(0, 16'h3344);
        bus_wr(2'd3, 8'h00);
        set_live(0, 16'h5566);
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd0, b); check("R6 second latch ignored low", 16'(b), 16'h0044);
        bus_rd(2'd0, b); check("R6 second latch ignored high", 16'(b), 16'h0033);
        bus_wr(2'd3, 8'h52);
        set_live(1, 16'hBEEF);
        bus_wr(2'd3, 8'h40);
        set_live(1, 16'h0000);
        bus_rd(2'd1, b); check("R5 lo-mode latch", 16'(b), 16'h00EF);
        bus_rd(2'd1, b); check("R5 lo-mode released", 16'(b), 16'h0000);
    endtask

    task automatic t_readback;
        logic [7:0] b;
        bus_wr(2'd3, 8'h34);
        bus_wr(2'd3, 8'hB6);
        bus_wr(2'd3, 8'h50);
        ch_out = 3'b100;
        set_live(0, 16'h0102);
        set_live(1, 16'h7788);
        set_live(2, 16'h0A0B);
        bus_wr(2'd3, 8'hCA);
        ch_out = 3'b011;
        set_live(0, 16'hFFFF);
        set_live(2, 16'hEEEE);
        bus_wr(2'd3, 8'hCA);
        bus_rd(2'd0, b); check("R8 R9 ch0 status", 16'(b), 16'h0034);
        bus_rd(2'd0, b); check("R7 ch0 latched low", 16'(b), 16'h0002);
        bus_rd(2'd0, b); check("R7 ch0 latched high", 16'(b), 16'h0001);
        bus_rd(2'd0, b); check("R9 ch0 live", 16'(b), 16'h00FF);
        bus_rd(2'd2, b); check("R8 ch2 status", 16'(b), 16'h00B6);
        bus_rd(2'd2, b); check("R7 ch2 latched low", 16'(b), 16'h000B);
        bus_rd(2'd2, b); check("R7 ch2 latched high", 16'(b), 16'h000A);
        bus_rd(2'd1, b); check("R7 ch1 not selected", 16'(b), 16'h0088);
        bus_wr(2'd3, 8'h34);
        ch_out = 3'b001;
        bus_wr(2'd3, 8'hE2);
        ch_out = 3'b000;
        bus_wr(2'd3, 8'hE2);
        bus_rd(2'd0, b); check("R6 status kept", 16'(b), 16'h00B4);
        bus_rd(2'd0, b); check("R7 status-only, live next", 16'(b), 16'h00FF);
    endtask

    task automatic t_ctrl_port;
        logic [7:0] b;
        bus_wr(2'd3, 8'h30);
        set_live(0, 16'hA1B2);
        bus_rd(2'd0, b); check("R10 low first", 16'(b), 16'h00B2);
        bus_rd(2'd3, b); check("R11 ctrl read zero", 16'(b), 16'h0000);
        bus_wr(2'd3, 8'hC0);
        check("R11 ctrl write no strobe", 16'(ld_stb), 16'd0);
        bus_rd(2'd0, b); check("R11 toggle kept", 16'(b), 16'h00A1);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_writes();
        t_prog_resets_toggle();
        t_live_reads();
        t_count_latch();
        t_readback();
        t_ctrl_port();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule